// File: doc/BRIEF.md
# Quadrature Position Counter with Mode Select

This block counts the position of a two-channel incremental encoder whose channels arrive on `enc_a_i` and `enc_b_i`. Both channels are synchronized to the system clock. They can then be inverted or exchanged before a mode decoder turns their edges into single-cycle up or down steps. A two-bit source field selects one of four behaviours: full quadrature decoding with four counts per encoder cycle, pulse plus direction level, up-only and down-only. The up-only and down-only modes count on one edge or on both edges of channel A.

The position is a 32-bit register that wraps at a programmable maximum. Software reads and writes the counter through a small byte-addressed register port, which has a write strobe and a combinational read. The counter holds its value while the enable bit is clear. An illegal simultaneous change of both channels in quadrature mode is dropped and sets a sticky error output.

Top module: `qpos_counter`

## Requirements
- R1: After reset the position, the maximum, the initial value and both control registers read 0. The error flag is low and counting is disabled, with quadrature selected.
- R2: Source field value 0 (decoder control bits 15:14) selects quadrature mode. In this mode every single edge of A or B moves the count by one. When A leads B the count goes up and `dir_o` is 1; when B leads A the count goes down and `dir_o` is 0.
- R3: In quadrature mode, a sample in which both conditioned channels changed leaves the count unchanged and sets `phase_err_o`. The flag stays set until reset.
- R4: Source value 1 selects pulse plus direction. Only a rising edge of A counts: up when B is 1 and down when B is 0. Falling edges of A and any change of B do not count.
- R5: Source value 2 counts up and source value 3 counts down, on A only, and B is ignored. Decoder control bit 11 set makes both edges of A count; bit 11 clear makes only rising edges count.
- R6: Counting happens only while module control bit 3 is set. While it is clear the position holds.
- R7: Counting up from the maximum wraps the position to 0, and counting down from 0 wraps it to the maximum.
- R8: A write to the position at byte offset 0x00 is taken only if the value does not exceed the maximum. A rejected write leaves the position unchanged. A write cycle of either kind suppresses counting in that cycle.
- R9: Decoder control bit 8 inverts A, bit 7 inverts B and bit 10 exchanges A and B, all before mode decoding. Changing these bits while the inputs are static produces no count.
- R10: The registers sit at these byte offsets: position at 0x00, initial value at 0x04, maximum at 0x08, decoder control at 0x28 and module control at 0x2A. Every register reads back what was written. Undefined control bits read 0.
- R11: Each input edge takes effect on the position on the third rising clock after the edge is presented. The position never moves by more than one step per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Encoder channel A, asynchronous |
| enc_b_i | input | 1 | Encoder channel B, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data; 16-bit registers use bits 15:0 |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| pos_o | output | 32 | Current position |
| dir_o | output | 1 | Direction of the most recent count, 1 = up |
| phase_err_o | output | 1 | Sticky quadrature phase error |

## Verification
The hardest states to reach are the ones that depend on control changes made while the inputs are static. An inversion or swap toggled under steady inputs must produce no count, yet it must alter how the next edge is decoded. The stimulus parks the encoder at a known level and then flips the conditioning bits. It checks that the position did not move, and only then applies one edge whose count direction differs from the unconditioned case. The wrap at zero and the double-transition error are reached from the quadrature vector table by stepping backwards from 0 and by jumping both channels in a single drive.

// File: rtl/qpos_pkg.sv
package qpos_pkg;
  typedef enum logic [1:0] {
    SRC_QUAD      = 2'd0,
    SRC_PULSE_DIR = 2'd1,
    SRC_UP        = 2'd2,
    SRC_DOWN      = 2'd3
  } src_e;

  typedef struct packed {
    src_e src;
    logic both_edges;
    logic swap;
    logic inv_a;
    logic inv_b;
  } dec_cfg_t;

  localparam int OFS_POS  = 'h00;
  localparam int OFS_INIT = 'h04;
  localparam int OFS_MAX  = 'h08;
  localparam int OFS_DEC  = 'h28;
  localparam int OFS_MOD  = 'h2A;

  localparam int DEC_SRC_LSB = 14;
  localparam int DEC_BOTH    = 11;
  localparam int DEC_SWAP    = 10;
  localparam int DEC_INV_A   = 8;
  localparam int DEC_INV_B   = 7;
  localparam int MOD_EN      = 3;
endpackage

// File: rtl/qpos_sync.sv
module qpos_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/qpos_decode.sv
module qpos_decode
  import qpos_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     a_i,
  input  logic     b_i,
  input  dec_cfg_t cfg_i,
  output logic     step_up_o,
  output logic     step_dn_o,
  output logic     err_o
);
  logic [1:0] raw_prev_q;
  logic [1:0] cur, old;
  logic       ea, eb, rise_a, illegal, ev;

  // conditioning is applied to both samples so control changes make no edge
  function automatic logic [1:0] cond(input logic [1:0] raw, input dec_cfg_t c);
    logic a, b;
    a = raw[1] ^ c.inv_a;
    b = raw[0] ^ c.inv_b;
    return c.swap ? {b, a} : {a, b};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_prev_q <= '0;
    else         raw_prev_q <= {a_i, b_i};
  end

  assign cur    = cond({a_i, b_i}, cfg_i);
  assign old    = cond(raw_prev_q, cfg_i);
  assign ea     = cur[1] ^ old[1];
  assign eb     = cur[0] ^ old[0];
  assign rise_a = cur[1] & ~old[1];
  assign ev     = cfg_i.both_edges ? ea : rise_a;

  always_comb begin
    step_up_o = 1'b0;
    step_dn_o = 1'b0;
    illegal   = 1'b0;
    if (en_i) begin
      unique case (cfg_i.src)
        SRC_QUAD: begin
          if (ea && eb) illegal = 1'b1;
          else if (ea) begin
            step_up_o = cur[1] != cur[0];
            step_dn_o = cur[1] == cur[0];
          end else if (eb) begin
            step_up_o = cur[0] == cur[1];
            step_dn_o = cur[0] != cur[1];
          end
        end
        SRC_PULSE_DIR: begin
          step_up_o = rise_a & cur[0];
          step_dn_o = rise_a & ~cur[0];
        end
        SRC_UP:   step_up_o = ev;
        SRC_DOWN: step_dn_o = ev;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_o <= 1'b0;
    else if (illegal) err_o <= 1'b1;
  end
endmodule

// File: rtl/qpos_position.sv
module qpos_position #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_up_i,
  input  logic             step_dn_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_val_i,
  input  logic [CNT_W-1:0] max_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             dir_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o <= '0;
      dir_o <= 1'b0;
    end else if (wr_i) begin
      if (wr_val_i <= max_i) pos_o <= wr_val_i;
    end else if (step_up_i) begin
      pos_o <= (pos_o >= max_i) ? '0 : pos_o + 1'b1;
      dir_o <= 1'b1;
    end else if (step_dn_i) begin
      pos_o <= (pos_o == '0) ? max_i : pos_o - 1'b1;
      dir_o <= 1'b0;
    end
  end
endmodule

// File: rtl/qpos_regs.sv
module qpos_regs
  import qpos_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int CTRL_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  pos_i,
  output logic [CNT_W-1:0]  rdata_o,
  output dec_cfg_t          cfg_o,
  output logic              en_o,
  output logic [CNT_W-1:0]  max_o,
  output logic              pos_wr_o,
  output logic [CNT_W-1:0]  pos_wdata_o
);
  localparam logic [CTRL_W-1:0] DEC_MASK =
    CTRL_W'((3 << DEC_SRC_LSB) | (1 << DEC_BOTH) | (1 << DEC_SWAP) |
            (1 << DEC_INV_A) | (1 << DEC_INV_B));
  localparam logic [CTRL_W-1:0] MOD_MASK = CTRL_W'(1 << MOD_EN);

  logic [CNT_W-1:0]  init_q, max_q;
  logic [CTRL_W-1:0] dec_q, mod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      max_q  <= '0;
      dec_q  <= '0;
      mod_q  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_W'(OFS_INIT): init_q <= wdata_i;
        ADDR_W'(OFS_MAX):  max_q  <= wdata_i;
        ADDR_W'(OFS_DEC):  dec_q  <= wdata_i[CTRL_W-1:0] & DEC_MASK;
        ADDR_W'(OFS_MOD):  mod_q  <= wdata_i[CTRL_W-1:0] & MOD_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFS_POS):  rdata_o = pos_i;
      ADDR_W'(OFS_INIT): rdata_o = init_q;
      ADDR_W'(OFS_MAX):  rdata_o = max_q;
      ADDR_W'(OFS_DEC):  rdata_o = CNT_W'(dec_q);
      ADDR_W'(OFS_MOD):  rdata_o = CNT_W'(mod_q);
      default:           rdata_o = '0;
    endcase
  end

  assign cfg_o.src        = src_e'(dec_q[DEC_SRC_LSB +: 2]);
  assign cfg_o.both_edges = dec_q[DEC_BOTH];
  assign cfg_o.swap       = dec_q[DEC_SWAP];
  assign cfg_o.inv_a      = dec_q[DEC_INV_A];
  assign cfg_o.inv_b      = dec_q[DEC_INV_B];
  assign en_o             = mod_q[MOD_EN];
  assign max_o            = max_q;
  assign pos_wr_o         = we_i && (addr_i == ADDR_W'(OFS_POS));
  assign pos_wdata_o      = wdata_i;
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int CTRL_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic [CNT_W-1:0]  pos_o,
  output logic              dir_o,
  output logic              phase_err_o
);
  logic [1:0]       ab_sync;
  dec_cfg_t         cfg;
  logic             cnt_en, step_up, step_dn, pos_wr;
  logic [CNT_W-1:0] max_val, pos_wdata;

  qpos_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({enc_a_i, enc_b_i}), .q_o(ab_sync)
  );

  qpos_regs #(.CNT_W(CNT_W), .CTRL_W(CTRL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .pos_i(pos_o), .rdata_o(reg_rdata_o), .cfg_o(cfg), .en_o(cnt_en),
    .max_o(max_val), .pos_wr_o(pos_wr), .pos_wdata_o(pos_wdata)
  );

  qpos_decode u_dec (
    .clk_i, .rst_ni, .en_i(cnt_en), .a_i(ab_sync[1]), .b_i(ab_sync[0]),
    .cfg_i(cfg), .step_up_o(step_up), .step_dn_o(step_dn), .err_o(phase_err_o)
  );

  qpos_position #(.CNT_W(CNT_W)) u_pos (
    .clk_i, .rst_ni, .step_up_i(step_up), .step_dn_i(step_dn), .wr_i(pos_wr),
    .wr_val_i(pos_wdata), .max_i(max_val), .pos_o(pos_o), .dir_o(dir_o)
  );
endmodule

// File: rtl/qpos_counter_chk.sv
module qpos_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_pos_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [CNT_W-1:0] max_i,
  input logic             en_i,
  input logic [CNT_W-1:0] pos_i,
  input logic             err_i,
  input logic             step_up_i,
  input logic             step_dn_i
);
  assert_hold_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_pos_i) |=> $stable(pos_i));

  assert_reject_above_max_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pos_i && wdata_i > max_i) |=> $stable(pos_i));

  assert_accept_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pos_i && wdata_i <= max_i) |=> pos_i == $past(wdata_i));

  assert_step_up_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_pos_i && step_up_i && pos_i < max_i) |=> pos_i == $past(pos_i) + 1'b1);

  assert_wrap_up_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_pos_i && step_up_i && pos_i == max_i) |=> pos_i == '0);

  assert_wrap_down_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_pos_i && step_dn_i && pos_i == '0) |=> pos_i == $past(max_i));

  assert_no_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_pos_i && !step_up_i && !step_dn_i) |=> $stable(pos_i));

  assert_one_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_up_i && step_dn_i));

  assert_err_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i);
endmodule

bind qpos_counter qpos_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_pos_i(pos_wr), .wdata_i(pos_wdata),
  .max_i(max_val), .en_i(cnt_en), .pos_i(pos_o), .err_i(phase_err_o),
  .step_up_i(step_up), .step_dn_i(step_dn)
);

// File: tb/qpos_counter_tb_top.sv
module qpos_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a = 1'b0, b = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pos;
  logic        dir, err;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  qpos_counter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enc_a_i(a), .enc_b_i(b),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .pos_o(pos), .dir_o(dir), .phase_err_o(err)
  );

  // {a, b, expected position, expected dir}; quadrature, max 100
  localparam logic [34:0] QUAD_VEC [10] = '{
    {1'b1, 1'b0, 32'd1,   1'b1}, {1'b1, 1'b1, 32'd2, 1'b1},
    {1'b0, 1'b1, 32'd3,   1'b1}, {1'b0, 1'b0, 32'd4, 1'b1},
    {1'b0, 1'b1, 32'd3,   1'b0}, {1'b1, 1'b1, 32'd2, 1'b0},
    {1'b1, 1'b0, 32'd1,   1'b0}, {1'b0, 1'b0, 32'd0, 1'b0},
    {1'b0, 1'b1, 32'd100, 1'b0}, {1'b0, 1'b0, 32'd0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ad, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = ad; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] ad, input logic [31:0] exp);
    @(negedge clk);
    addr = ad;
    #1 check(req, rdata, exp);
  endtask

  task automatic drive(input logic na, input logic nb);
    @(negedge clk);
    a = na; b = nb;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 pos", pos, 0);
    check("R1 err", {31'd0, err}, 0);
    rd_check("R1 max", 8'h08, 0);
    rd_check("R1 dec", 8'h28, 0);
    rd_check("R1 mod", 8'h2A, 0);
    drive(1'b1, 1'b0);
    check("R1 disabled after reset", pos, 0);
    drive(1'b0, 1'b0);

    wr(8'h08, 32'd100);
    wr(8'h2A, 32'h8);
    rd_check("R10 max readback", 8'h08, 100);
    rd_check("R10 mod readback", 8'h2A, 8);

    // R2 / R7 quadrature table
    foreach (QUAD_VEC[i]) begin
      drive(QUAD_VEC[i][34], QUAD_VEC[i][33]);
      check($sformatf("R2 R7 vec%0d pos", i), pos, QUAD_VEC[i][32:1]);
      check($sformatf("R2 vec%0d dir", i), {31'd0, dir}, {31'd0, QUAD_VEC[i][0]});
    end

    // R3 illegal double transition
    drive(1'b1, 1'b1);
    check("R3 pos held", pos, 0);
    check("R3 err set", {31'd0, err}, 1);
    drive(1'b0, 1'b0);
    check("R3 err sticky", {31'd0, err}, 1);
    check("R3 pos held 2", pos, 0);

    // R6 disabled hold
    wr(8'h2A, 32'h0);
    drive(1'b1, 1'b0);
    check("R6 hold", pos, 0);
    drive(1'b0, 1'b0);
    wr(8'h2A, 32'h8);

    // R9 inversion of A
    wr(8'h28, 32'h0100);
    repeat (4) @(negedge clk);
    check("R9 no count on invert", pos, 0);
    drive(1'b0, 1'b1);
    check("R9 invert A up", pos, 1);
    drive(1'b0, 1'b0);
    wr(8'h28, 32'h0);
    repeat (4) @(negedge clk);
    check("R9 no count on restore", pos, 0);

    // R9 swap
    wr(8'h28, 32'h0400);
    drive(1'b0, 1'b1);
    check("R9 swap up", pos, 1);
    wr(8'h28, 32'h0);
    repeat (4) @(negedge clk);
    check("R9 no count on unswap", pos, 1);
    drive(1'b0, 1'b0);
    check("R9 after unswap", pos, 2);

    // R4 pulse and direction
    wr(8'h28, 32'h4000);
    drive(1'b0, 1'b1);
    check("R4 B alone", pos, 2);
    drive(1'b1, 1'b1);
    check("R4 rise up", pos, 3);
    drive(1'b0, 1'b1);
    check("R4 fall ignored", pos, 3);
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    check("R4 rise down", pos, 2);
    check("R4 dir", {31'd0, dir}, 0);
    drive(1'b0, 1'b0);

    // R5 count up / down
    wr(8'h28, 32'h8000);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    check("R5 up rising only", pos, 3);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    check("R5 B ignored", pos, 3);
    wr(8'h28, 32'h8800);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    check("R5 up both edges", pos, 5);
    wr(8'h28, 32'hC000);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    check("R5 down rising only", pos, 4);
    wr(8'h28, 32'hC800);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    check("R5 down both edges", pos, 2);
    rd_check("R10 dec readback", 8'h28, 32'hC800);
    wr(8'h28, 32'hFFFF);
    rd_check("R10 undefined bits zero", 8'h28, 32'hCD80);
    wr(8'h28, 32'hC000);

    // R7 / R8 software writes and down wrap
    wr(8'h00, 32'd0);
    check("R8 write zero", pos, 0);
    drive(1'b1, 1'b0);
    check("R7 down wrap", pos, 100);
    drive(1'b0, 1'b0);
    wr(8'h00, 32'd101);
    check("R8 reject above max", pos, 100);
    wr(8'h00, 32'd50);
    check("R8 accept", pos, 50);
    rd_check("R10 pos readback", 8'h00, 50);
    wr(8'h04, 32'h1234);
    rd_check("R10 init readback", 8'h04, 32'h1234);

    // R11 latency: edge presented after a negedge shows on the third posedge
    @(negedge clk);
    a = 1'b1;
    @(negedge clk); check("R11 lat 1", pos, 50);
    @(negedge clk); check("R11 lat 2", pos, 50);
    @(negedge clk); check("R11 lat 3", pos, 49);
    drive(1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule